// File: doc/BRIEF.md
# Pair-Difference Overload Channel

This block adds a set of extra, non-orthogonal channels to a code-shared on-chip bus. The orthogonal users and these channels all feed one summed chip stream. With N chips per symbol there are N/2 chip pairs, so the block provides N/2 extra lanes. In a bus that is already full of orthogonal users, that raises the number of bits carried per symbol by about half.

Each lane has two parts. The encoder side gates a one-hot code with the lane's data bit. The chip it produces goes to the bus adder next to the orthogonal users' chips. The decoder side never correlates. It watches only the least significant bit of the bus sum on the two chips of its own pair. The orthogonal users alone always leave an even difference between the two sums of any pair, so an odd difference means the lane sent a 1. One register holds the first LSB, and one XOR with the second LSB gives the recovered bit.

The chip sequencer drives `chip_en` and `chip_idx`. A low `chip_en` stalls the symbol, and every decoder keeps its state through the stall. The outside adder returns bit 0 of the bus sum on `bus_sum_lsb` in the same cycle as the chip index it belongs to.

Top module: `pdov_channel`

## Requirements
- R1: While reset is applied, and until the first enabled chip completes a pair, every `rx_valid` and `rx_bit` output is 0.
- R2: `pd_chip[l]` is 1 exactly when `chip_en` is 1, `pd_data[l]` is 1 and `chip_idx` equals 2l. Written MSB first over N chips, the code of lane l has a single 1 at bit N-1-2l. For N=8 the codes are 8'h80, 8'h20, 8'h08 and 8'h02.
- R3: A lane whose data bit is 0 sends only zero chips. In any one cycle at most one bit of `pd_chip` is 1.
- R4: When `chip_en` is 0, `pd_chip` is all zero.
- R5: After an enabled chip 2l+1, `rx_bit[l]` equals the `bus_sum_lsb` seen at the enabled chip 2l XOR the `bus_sum_lsb` seen at the enabled chip 2l+1.
- R6: `rx_valid[l]` is 1 for exactly the one cycle that follows an enabled cycle with `chip_idx` = 2l+1, and is 0 in every other cycle. At most one lane is valid in a cycle.
- R7: A cycle with `chip_en` at 0 changes no decoder state. It raises no valid, leaves `rx_bit` as it was, and keeps the stored first LSB of a pair that the stall interrupts.
- R8: `rx_bit[l]` changes only in a cycle where `rx_valid[l]` is 1.
- R9: With as many as N-1 orthogonal users sharing the summed stream, each lane's recovered bit equals the data bit it sent in that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Chip advance; 0 stalls the symbol |
| chip_idx | input | $clog2(NUM_CHIPS) | Index of the current chip within the symbol |
| pd_data | input | NUM_CHIPS/2 | Data bit of each overload lane for the current symbol |
| bus_sum_lsb | input | 1 | Bit 0 of the bus sum for the current chip |
| pd_chip | output | NUM_CHIPS/2 | Encoded chip of each lane, to the bus adder |
| rx_bit | output | NUM_CHIPS/2 | Recovered bit of each lane |
| rx_valid | output | NUM_CHIPS/2 | One-cycle strobe marking a new recovered bit |

## Verification
The bench builds the block with NUM_CHIPS = 8. That gives four lanes whose pairs cover every chip of the symbol. Seven orthogonal users run on the nonzero rows of the 8-chip Walsh set. Their spread chips are summed with the lane chips, so the parity property is tested under the full interference allowed at this length. Random stalls fall between any two chips, including inside a pair, and during a stall the index and sum bit are random noise. This tests that stored LSBs survive a stall and that no stray strobe appears.

// File: rtl/pdov_pkg.sv
package pdov_pkg;

  localparam int MAX_CHIPS = 64;

  // Chip-order mask of lane l: element k is the chip sent at index k.
  // The single 1 sits at index 2l (bit N-1-2l of the MSB-first word).
  function automatic logic [MAX_CHIPS-1:0] pd_chip_mask(input int lane);
    logic [MAX_CHIPS-1:0] m;
    m = '0;
    m[2*lane] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pdov_rst_sync.sv
module pdov_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/pdov_encoder.sv
module pdov_encoder #(
  parameter int NUM_CHIPS = 8,
  parameter int LANE      = 0,
  localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
  input  logic              chip_en,
  input  logic [CHIP_W-1:0] chip_idx,
  input  logic              data_bit,
  output logic              chip_out
);

  localparam logic [pdov_pkg::MAX_CHIPS-1:0] FULL_MASK = pdov_pkg::pd_chip_mask(LANE);
  localparam logic [NUM_CHIPS-1:0] CODE_MASK = FULL_MASK[NUM_CHIPS-1:0];

  logic code_chip;

  always_comb begin
    code_chip = CODE_MASK[chip_idx];
    chip_out  = chip_en & data_bit & code_chip;
  end

endmodule

// File: rtl/pdov_decoder.sv
module pdov_decoder #(
  parameter int NUM_CHIPS = 8,
  parameter int LANE      = 0,
  localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [CHIP_W-1:0] chip_idx,
  input  logic              sum_lsb,
  output logic              bit_out,
  output logic              valid_out
);

  localparam logic [CHIP_W-1:0] FIRST_IDX  = CHIP_W'(2 * LANE);
  localparam logic [CHIP_W-1:0] SECOND_IDX = CHIP_W'(2 * LANE + 1);

  logic lsb_q;
  logic bit_q;
  logic vld_q;
  logic lsb_en;
  logic close_en;
  logic bit_d;
  logic vld_d;

  always_comb begin
    lsb_en   = chip_en && (chip_idx == FIRST_IDX);
    close_en = chip_en && (chip_idx == SECOND_IDX);
    bit_d    = bit_q;
    vld_d    = 1'b0;
    if (close_en) begin
      bit_d = lsb_q ^ sum_lsb;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
    end else if (lsb_en) begin
      lsb_q <= sum_lsb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign bit_out   = bit_q;
  assign valid_out = vld_q;

endmodule

// File: rtl/pdov_channel.sv
module pdov_channel #(
  parameter int NUM_CHIPS = 8,
  localparam int CHIP_W   = $clog2(NUM_CHIPS),
  localparam int NUM_PD   = NUM_CHIPS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [CHIP_W-1:0] chip_idx,
  input  logic [NUM_PD-1:0] pd_data,
  input  logic              bus_sum_lsb,
  output logic [NUM_PD-1:0] pd_chip,
  output logic [NUM_PD-1:0] rx_bit,
  output logic [NUM_PD-1:0] rx_valid
);

  logic rst_sync_n;

  pdov_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar l = 0; l < NUM_PD; l++) begin : g_lane
    pdov_encoder #(
      .NUM_CHIPS (NUM_CHIPS),
      .LANE      (l)
    ) u_enc (
      .chip_en  (chip_en),
      .chip_idx (chip_idx),
      .data_bit (pd_data[l]),
      .chip_out (pd_chip[l])
    );

    pdov_decoder #(
      .NUM_CHIPS (NUM_CHIPS),
      .LANE      (l)
    ) u_dec (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .chip_en   (chip_en),
      .chip_idx  (chip_idx),
      .sum_lsb   (bus_sum_lsb),
      .bit_out   (rx_bit[l]),
      .valid_out (rx_valid[l])
    );
  end

endmodule

// File: rtl/pdov_checker.sv
module pdov_checker #(
  parameter int NUM_CHIPS = 8,
  localparam int CHIP_W   = $clog2(NUM_CHIPS),
  localparam int NUM_PD   = NUM_CHIPS / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic [CHIP_W-1:0] chip_idx,
  input logic [NUM_PD-1:0] pd_chip,
  input logic [NUM_PD-1:0] rx_bit,
  input logic [NUM_PD-1:0] rx_valid
);

  a_r3_one_chip_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pd_chip));

  a_r4_idle_no_chip: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pd_chip == '0));

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_valid));

  a_r7_stall_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (rx_valid == '0));

  for (genvar l = 0; l < NUM_PD; l++) begin : g_lane_chk
    localparam logic [CHIP_W-1:0] SECOND_IDX = CHIP_W'(2 * l + 1);

    a_r6_strobe_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && chip_idx == SECOND_IDX) |=> rx_valid[l]);

    a_r6_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(chip_en && chip_idx == SECOND_IDX) |=> !rx_valid[l]);

    a_r8_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid[l] |-> (rx_bit[l] == $past(rx_bit[l])));
  end

endmodule

bind pdov_channel pdov_checker #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .chip_en  (chip_en),
  .chip_idx (chip_idx),
  .pd_chip  (pd_chip),
  .rx_bit   (rx_bit),
  .rx_valid (rx_valid)
);

// File: tb/pdov_channel_test.sv
`timescale 1ns/1ps
module pdov_channel_test;

  localparam int N      = 8;
  localparam int CW     = 3;
  localparam int NPD    = N / 2;
  localparam int NUSERS = N - 1;

  logic           clk;
  logic           rst_n;
  logic           chip_en;
  logic [CW-1:0]  chip_idx;
  logic [NPD-1:0] pd_data;
  logic           bus_sum_lsb;
  logic [NPD-1:0] pd_chip;
  logic [NPD-1:0] rx_bit;
  logic [NPD-1:0] rx_valid;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;
  logic [NPD-1:0] exp_bit;

  pdov_channel #(.NUM_CHIPS(N)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .chip_idx    (chip_idx),
    .pd_data     (pd_data),
    .bus_sum_lsb (bus_sum_lsb),
    .pd_chip     (pd_chip),
    .rx_bit      (rx_bit),
    .rx_valid    (rx_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected lane chips: single 1 at chip 2l when data is 1 (R2).
  function automatic logic [NPD-1:0] exp_chips(input logic [NPD-1:0] d, input int k);
    logic [NPD-1:0] c;
    for (int l = 0; l < NPD; l++) c[l] = d[l] && (k == 2 * l);
    return c;
  endfunction

  // Bus sum: Walsh users on rows 1..N-1 plus lane chips, plus an even junk offset.
  function automatic int bus_sum(input logic [NUSERS-1:0] w, input logic [NPD-1:0] d,
                                 input int k, input int junk);
    int s;
    logic [NPD-1:0] c;
    s = 0;
    for (int u = 1; u <= NUSERS; u++) begin
      logic [CW-1:0] row;
      logic [CW-1:0] kk;
      row = CW'(u);
      kk  = CW'(k);
      s += int'(w[u-1] ^ (^(row & kk)));
    end
    c = exp_chips(d, k);
    for (int l = 0; l < NPD; l++) s += int'(c[l]);
    return s + 2 * junk;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stall_cycle();
    @(negedge clk);
    chip_en     = 1'b0;
    chip_idx    = CW'($urandom_range(0, N - 1));
    bus_sum_lsb = 1'($urandom_range(0, 1));
    #1;
    check(pd_chip == '0, "R4 chips quiet when stalled", int'(pd_chip), 0);
    @(posedge clk);
    #1;
    check(rx_valid == '0, "R7 no strobe after stall", int'(rx_valid), 0);
    check(rx_bit == exp_bit, "R7 bits held over stall", int'(rx_bit), int'(exp_bit));
  endtask

  task automatic run_symbol(input logic [NPD-1:0] d, input logic [NUSERS-1:0] w,
                            input int stall_pct);
    logic [NPD-1:0] ones_seen;
    ones_seen = '0;
    for (int k = 0; k < N; k++) begin
      logic [NPD-1:0] ec;
      logic [NPD-1:0] ev;
      int s;
      if (int'($urandom_range(0, 99)) < stall_pct) stall_cycle();
      @(negedge clk);
      chip_en     = 1'b1;
      chip_idx    = CW'(k);
      pd_data     = d;
      s           = bus_sum(w, d, k, int'($urandom_range(0, 15)));
      bus_sum_lsb = 1'(s);
      ec = exp_chips(d, k);
      #1;
      check(pd_chip == ec, "R2 encoded chip", int'(pd_chip), int'(ec));
      ones_seen |= pd_chip;
      @(posedge clk);
      #1;
      for (int l = 0; l < NPD; l++) ev[l] = (k == 2 * l + 1);
      check(rx_valid == ev, "R6 strobe timing", int'(rx_valid), int'(ev));
      for (int l = 0; l < NPD; l++) if (ev[l]) exp_bit[l] = d[l];
      check(rx_bit == exp_bit, "R9 R5 R8 recovered bits", int'(rx_bit), int'(exp_bit));
    end
    check(ones_seen == d, "R3 chips only from lanes sending 1", int'(ones_seen), int'(d));
  endtask

  initial begin
    void'($urandom(32'h0D1FF5E7));
    rst_n       = 1'b0;
    chip_en     = 1'b0;
    chip_idx    = '0;
    pd_data     = '0;
    bus_sum_lsb = 1'b0;
    exp_bit     = '0;
    repeat (3) @(negedge clk);
    check(rx_valid == '0 && rx_bit == '0, "R1 reset state", int'({rx_valid, rx_bit}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_valid == '0 && rx_bit == '0, "R1 state after release",
          int'({rx_valid, rx_bit}), 0);

    // Directed corners: all lanes 1, all lanes 0, full and empty orthogonal load.
    run_symbol('1, '1, 0);
    run_symbol('0, '1, 0);
    run_symbol('1, '0, 0);
    run_symbol(4'b0101, 7'b1010101, 0);
    // Stall inside every pair (R7): heavy stall rate.
    run_symbol(4'b1010, 7'b0110011, 90);
    // Random symbols with occasional stalls.
    for (int i = 0; i < 400; i++)
      run_symbol(NPD'($urandom), NUSERS'($urandom), 20);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule